// File: doc/BRIEF.md
# Host Cycle Address Window Decoder

This block sits on the host side of a serial peripheral bridge and decides, in the same cycle that an address arrives, whether the bridge should claim that IO or memory cycle. It holds a small set of configuration registers, which a simple write port programs and an asynchronous read port returns. These are two enable registers, eight generic IO windows and four generic MMIO windows. A set of fixed legacy IO ports can be switched on with dedicated enable bits, without using a generic window.

Each request carries a valid flag, a memory/IO qualifier and a 32-bit address. The decoder reports a hit flag, the kind of match and the index of the matching window. If subtractive decode is switched on, a valid cycle that matches nothing is still claimed. A clear command first drops every enable bit, optionally keeping the port-0x80 bit. On the next clock edge it zeroes every base and size register.

Top module: `decwin_top`

## Requirements
- R1: After reset every configuration register reads 0 and no request is claimed; with no hit, hit_kind_o is 0 (none) and win_idx_o is 0.
- R2: On an IO cycle to port 0x80 with primary enable bit 0 set, the cycle is claimed with hit_kind_o = 1 (fixed) and win_idx_o = 0; neighbouring ports are not claimed by this bit.
- R3: Ports 0x60 and 0x64 are both claimed through primary enable bit 1, as fixed hits with win_idx_o = 1; port 0x62 is not.
- R4: Ports 0x2E and 0x2F are both claimed through primary enable bit 2, as fixed hits with win_idx_o = 2.
- R5: Generic IO window i (16-bit base at register 0x10+i, 8-bit size field at 0x18+i) claims an IO cycle with base <= addr[15:0] <= base + size field, which makes a field of 0 a one-byte window; the result is hit_kind_o = 2 and win_idx_o = i, and the window takes part only while its enable bit is set.
- R6: Generic MMIO window j (32-bit base at 0x20+j, 16-bit size field at 0x28+j) claims a memory cycle with base <= addr <= base + size field, where the upper bound is computed without wrapping past 0xFFFFFFFF; the result is hit_kind_o = 3 and win_idx_o = j.
- R7: The primary enable register (0x00) holds bit 0 port 0x80, bit 1 ports 0x60/0x64, bit 2 ports 0x2E/0x2F, bit 3 subtractive decode, bits 7:4 IO windows 0-3 and bits 9:8 MMIO windows 0-1. The extended enable register (0x01) holds bits 3:0 for IO windows 4-7 and bits 5:4 for MMIO windows 2-3.
- R8: When several sources match, a fixed port takes precedence over a generic window, and among generic windows the lowest index is reported.
- R9: With bit 3 set, a valid cycle that matches no enabled decode is claimed with hit_kind_o = 4 and win_idx_o = 0; with bit 3 clear it is not claimed; an invalid request is never claimed.
- R10: A clear pulse zeroes both enable registers at the next edge, except that bit 0 keeps its value when clr_keep_p80_i is high. On the following edge it zeroes every base and size register. Register writes in those two cycles are ignored.
- R11: Register reads return the stored value zero-extended to 32 bits; bits beyond a field's width are dropped on write, and unmapped addresses read 0 and ignore writes.
- R12: Fixed ports and IO windows match only IO cycles (req_mem_i = 0), and on those cycles address bits 31:16 are ignored. MMIO windows match only memory cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 6 | Register address for read and write |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| clr_i | input | 1 | Start of the two-step decoder clear |
| clr_keep_p80_i | input | 1 | Keep the port-0x80 enable during a clear |
| req_valid_i | input | 1 | Host cycle valid |
| req_mem_i | input | 1 | 1 = memory cycle, 0 = IO cycle |
| req_addr_i | input | 32 | Host cycle address |
| hit_o | output | 1 | Cycle is claimed |
| hit_kind_o | output | 3 | 0 none, 1 fixed, 2 IO window, 3 MMIO window, 4 subtractive |
| win_idx_o | output | 3 | Fixed port group or window index |

## Verification
The assertions assume that clr_i and clr_keep_p80_i are low while reset is applied, so that the clear checks, which look two cycles back, start from a quiet state. They also assume that req_mem_i is held steady for as long as req_valid_i is high within a cycle. The bench changes every input only on the falling edge and keeps clr_i low during reset. Random register writes and decodes come from a fixed seed, and the addresses are drawn close to the programmed bases so that window edges and overlaps are hit often.

// File: rtl/decwin_pkg.sv
package decwin_pkg;
  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_FIXED = 3'd1,
    KIND_IO    = 3'd2,
    KIND_MEM   = 3'd3,
    KIND_SUB   = 3'd4
  } hit_kind_e;

  localparam int EN_P80     = 0;
  localparam int EN_KBC     = 1;
  localparam int EN_SIO     = 2;
  localparam int EN_SUB     = 3;
  localparam int EN_WIN_LSB = 4;

  localparam int CFG_AW = 6;
  localparam logic [CFG_AW-1:0] A_DEC_EN   = 6'h00;
  localparam logic [CFG_AW-1:0] A_DEC_EXT  = 6'h01;
  localparam logic [CFG_AW-1:0] A_IO_BASE  = 6'h10;
  localparam logic [CFG_AW-1:0] A_IO_SIZE  = 6'h18;
  localparam logic [CFG_AW-1:0] A_MEM_BASE = 6'h20;
  localparam logic [CFG_AW-1:0] A_MEM_SIZE = 6'h28;
endpackage

// File: rtl/decwin_regs.sv
module decwin_regs
  import decwin_pkg::*;
#(
  parameter int IO_WIN  = 8,
  parameter int MEM_WIN = 4,
  parameter int IO_GRP  = 4,
  parameter int MEM_GRP = 2,
  parameter int IO_AW   = 16,
  parameter int IO_SW   = 8,
  parameter int MEM_AW  = 32,
  parameter int MEM_SW  = 16,
  parameter int DW      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [DW-1:0]     cfg_wdata_i,
  output logic [DW-1:0]     cfg_rdata_o,
  input  logic              clr_i,
  input  logic              clr_keep_p80_i,
  output logic [3:0]        fix_en_o,
  output logic [IO_WIN-1:0] io_en_o,
  output logic [MEM_WIN-1:0] mem_en_o,
  output logic [IO_AW-1:0]  io_base_o  [IO_WIN],
  output logic [IO_SW-1:0]  io_size_o  [IO_WIN],
  output logic [MEM_AW-1:0] mem_base_o [MEM_WIN],
  output logic [MEM_SW-1:0] mem_size_o [MEM_WIN]
);
  localparam int IO_XW = IO_WIN - IO_GRP;
  localparam int DEC_W = EN_WIN_LSB + IO_GRP + MEM_GRP;
  localparam int EXT_W = IO_XW + (MEM_WIN - MEM_GRP);

  logic [DEC_W-1:0] dec_en_q;
  logic [EXT_W-1:0] ext_en_q;
  logic             clr_ph_q;
  logic             wr_ok;

  // writes are dropped while either clear step is in progress
  assign wr_ok = cfg_we_i & ~clr_i & ~clr_ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_en_q <= '0;
      ext_en_q <= '0;
      clr_ph_q <= 1'b0;
    end else begin
      clr_ph_q <= clr_i;
      if (clr_i) begin
        dec_en_q <= clr_keep_p80_i ? (dec_en_q & DEC_W'(1)) : '0;
        ext_en_q <= '0;
      end else if (wr_ok) begin
        if (cfg_addr_i == A_DEC_EN)  dec_en_q <= cfg_wdata_i[DEC_W-1:0];
        if (cfg_addr_i == A_DEC_EXT) ext_en_q <= cfg_wdata_i[EXT_W-1:0];
      end
    end
  end

  assign fix_en_o = dec_en_q[3:0];

  for (genvar gi = 0; gi < IO_WIN; gi++) begin : g_io
    logic [IO_AW-1:0] base_q;
    logic [IO_SW-1:0] size_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        size_q <= '0;
      end else if (clr_ph_q) begin
        base_q <= '0;
        size_q <= '0;
      end else if (wr_ok) begin
        if (cfg_addr_i == A_IO_BASE + CFG_AW'(gi)) base_q <= cfg_wdata_i[IO_AW-1:0];
        if (cfg_addr_i == A_IO_SIZE + CFG_AW'(gi)) size_q <= cfg_wdata_i[IO_SW-1:0];
      end
    end
    assign io_base_o[gi] = base_q;
    assign io_size_o[gi] = size_q;
    if (gi < IO_GRP) begin : g_pri
      assign io_en_o[gi] = dec_en_q[EN_WIN_LSB+gi];
    end else begin : g_ext
      assign io_en_o[gi] = ext_en_q[gi-IO_GRP];
    end
  end

  for (genvar gj = 0; gj < MEM_WIN; gj++) begin : g_mem
    logic [MEM_AW-1:0] base_q;
    logic [MEM_SW-1:0] size_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        size_q <= '0;
      end else if (clr_ph_q) begin
        base_q <= '0;
        size_q <= '0;
      end else if (wr_ok) begin
        if (cfg_addr_i == A_MEM_BASE + CFG_AW'(gj)) base_q <= cfg_wdata_i[MEM_AW-1:0];
        if (cfg_addr_i == A_MEM_SIZE + CFG_AW'(gj)) size_q <= cfg_wdata_i[MEM_SW-1:0];
      end
    end
    assign mem_base_o[gj] = base_q;
    assign mem_size_o[gj] = size_q;
    if (gj < MEM_GRP) begin : g_pri
      assign mem_en_o[gj] = dec_en_q[EN_WIN_LSB+IO_GRP+gj];
    end else begin : g_ext
      assign mem_en_o[gj] = ext_en_q[IO_XW+gj-MEM_GRP];
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_addr_i == A_DEC_EN)  cfg_rdata_o = DW'(dec_en_q);
    if (cfg_addr_i == A_DEC_EXT) cfg_rdata_o = DW'(ext_en_q);
    for (int i = 0; i < IO_WIN; i++) begin
      if (cfg_addr_i == A_IO_BASE + CFG_AW'(i)) cfg_rdata_o = DW'(io_base_o[i]);
      if (cfg_addr_i == A_IO_SIZE + CFG_AW'(i)) cfg_rdata_o = DW'(io_size_o[i]);
    end
    for (int j = 0; j < MEM_WIN; j++) begin
      if (cfg_addr_i == A_MEM_BASE + CFG_AW'(j)) cfg_rdata_o = DW'(mem_base_o[j]);
      if (cfg_addr_i == A_MEM_SIZE + CFG_AW'(j)) cfg_rdata_o = DW'(mem_size_o[j]);
    end
  end
endmodule

// File: rtl/decwin_fixed.sv
module decwin_fixed #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    en_i,
  output logic          hit_o,
  output logic [1:0]    idx_o
);
  logic p80, kbc, sio;

  assign p80 = en_i[0] && (addr_i == AW'(16'h0080));
  assign kbc = en_i[1] && ((addr_i == AW'(16'h0060)) || (addr_i == AW'(16'h0064)));
  assign sio = en_i[2] && ((addr_i == AW'(16'h002E)) || (addr_i == AW'(16'h002F)));

  assign hit_o = p80 | kbc | sio;
  assign idx_o = p80 ? 2'd0 : kbc ? 2'd1 : 2'd2;
endmodule

// File: rtl/decwin_match.sv
module decwin_match #(
  parameter int N  = 8,
  parameter int AW = 16,
  parameter int SW = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  en_i,
  input  logic [AW-1:0] base_i [N],
  input  logic [SW-1:0] size_i [N],
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] win_hit;

  for (genvar gi = 0; gi < N; gi++) begin : g_cmp
    logic [AW:0] last_a;
    // one extra bit so base + size never wraps to a low address
    assign last_a     = {1'b0, base_i[gi]} + (AW+1)'(size_i[gi]);
    assign win_hit[gi] = en_i[gi] && (addr_i >= base_i[gi]) && ({1'b0, addr_i} <= last_a);
  end

  assign hit_o = |win_hit;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (win_hit[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/decwin_top.sv
module decwin_top
  import decwin_pkg::*;
#(
  parameter int IO_WIN  = 8,
  parameter int MEM_WIN = 4,
  parameter int IO_GRP  = 4,
  parameter int MEM_GRP = 2,
  parameter int IO_AW   = 16,
  parameter int IO_SW   = 8,
  parameter int MEM_AW  = 32,
  parameter int MEM_SW  = 16,
  parameter int DW      = 32,
  parameter int IO_IW   = $clog2(IO_WIN),
  parameter int MEM_IW  = $clog2(MEM_WIN),
  parameter int IDX_W   = (IO_IW > MEM_IW) ? ((IO_IW > 2) ? IO_IW : 2)
                                            : ((MEM_IW > 2) ? MEM_IW : 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [DW-1:0]     cfg_wdata_i,
  output logic [DW-1:0]     cfg_rdata_o,
  input  logic              clr_i,
  input  logic              clr_keep_p80_i,
  input  logic              req_valid_i,
  input  logic              req_mem_i,
  input  logic [MEM_AW-1:0] req_addr_i,
  output logic              hit_o,
  output logic [2:0]        hit_kind_o,
  output logic [IDX_W-1:0]  win_idx_o
);
  logic [3:0]         fix_en;
  logic [IO_WIN-1:0]  io_en;
  logic [MEM_WIN-1:0] mem_en;
  logic [IO_AW-1:0]   io_base  [IO_WIN];
  logic [IO_SW-1:0]   io_size  [IO_WIN];
  logic [MEM_AW-1:0]  mem_base [MEM_WIN];
  logic [MEM_SW-1:0]  mem_size [MEM_WIN];

  decwin_regs #(
    .IO_WIN(IO_WIN), .MEM_WIN(MEM_WIN), .IO_GRP(IO_GRP), .MEM_GRP(MEM_GRP),
    .IO_AW(IO_AW), .IO_SW(IO_SW), .MEM_AW(MEM_AW), .MEM_SW(MEM_SW), .DW(DW)
  ) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cfg_we_i       (cfg_we_i),
    .cfg_addr_i     (cfg_addr_i),
    .cfg_wdata_i    (cfg_wdata_i),
    .cfg_rdata_o    (cfg_rdata_o),
    .clr_i          (clr_i),
    .clr_keep_p80_i (clr_keep_p80_i),
    .fix_en_o       (fix_en),
    .io_en_o        (io_en),
    .mem_en_o       (mem_en),
    .io_base_o      (io_base),
    .io_size_o      (io_size),
    .mem_base_o     (mem_base),
    .mem_size_o     (mem_size)
  );

  logic [IO_AW-1:0]  io_addr;
  logic              io_cyc, mem_cyc;
  logic              fix_hit, io_hit, mem_hit;
  logic [1:0]        fix_idx;
  logic [IO_IW-1:0]  io_idx;
  logic [MEM_IW-1:0] mem_idx;

  assign io_addr = req_addr_i[IO_AW-1:0];
  assign io_cyc  = req_valid_i & ~req_mem_i;
  assign mem_cyc = req_valid_i &  req_mem_i;

  decwin_fixed #(.AW(IO_AW)) u_fixed (
    .addr_i (io_addr),
    .en_i   (fix_en[2:0]),
    .hit_o  (fix_hit),
    .idx_o  (fix_idx)
  );

  decwin_match #(.N(IO_WIN), .AW(IO_AW), .SW(IO_SW), .IW(IO_IW)) u_io_match (
    .addr_i (io_addr),
    .en_i   (io_en),
    .base_i (io_base),
    .size_i (io_size),
    .hit_o  (io_hit),
    .idx_o  (io_idx)
  );

  decwin_match #(.N(MEM_WIN), .AW(MEM_AW), .SW(MEM_SW), .IW(MEM_IW)) u_mem_match (
    .addr_i (req_addr_i),
    .en_i   (mem_en),
    .base_i (mem_base),
    .size_i (mem_size),
    .hit_o  (mem_hit),
    .idx_o  (mem_idx)
  );

  hit_kind_e kind;

  always_comb begin
    kind      = KIND_NONE;
    win_idx_o = '0;
    if (io_cyc && fix_hit) begin
      kind      = KIND_FIXED;
      win_idx_o = IDX_W'(fix_idx);
    end else if (io_cyc && io_hit) begin
      kind      = KIND_IO;
      win_idx_o = IDX_W'(io_idx);
    end else if (mem_cyc && mem_hit) begin
      kind      = KIND_MEM;
      win_idx_o = IDX_W'(mem_idx);
    end else if (req_valid_i && fix_en[EN_SUB]) begin
      kind      = KIND_SUB;
    end
  end

  assign hit_kind_o = kind;
  assign hit_o      = (kind != KIND_NONE);
endmodule

// File: rtl/decwin_chk.sv
module decwin_chk
  import decwin_pkg::*;
#(
  parameter int IO_WIN  = 8,
  parameter int MEM_WIN = 4,
  parameter int IO_AW   = 16,
  parameter int IO_SW   = 8,
  parameter int MEM_AW  = 32,
  parameter int MEM_SW  = 16,
  parameter int IDX_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_i,
  input logic               clr_keep_p80_i,
  input logic               req_valid_i,
  input logic               req_mem_i,
  input logic               hit_o,
  input logic [2:0]         hit_kind_o,
  input logic [IDX_W-1:0]   win_idx_o,
  input logic [3:0]         fix_en,
  input logic [IO_WIN-1:0]  io_en,
  input logic [MEM_WIN-1:0] mem_en,
  input logic [IO_AW-1:0]   io_base  [IO_WIN],
  input logic [IO_SW-1:0]   io_size  [IO_WIN],
  input logic [MEM_AW-1:0]  mem_base [MEM_WIN],
  input logic [MEM_SW-1:0]  mem_size [MEM_WIN]
);
  logic win_or;
  logic io_sel_en, mem_sel_en;

  always_comb begin
    win_or = 1'b0;
    for (int i = 0; i < IO_WIN; i++) win_or = win_or | (|io_base[i]) | (|io_size[i]);
    for (int j = 0; j < MEM_WIN; j++) win_or = win_or | (|mem_base[j]) | (|mem_size[j]);
    io_sel_en  = 1'b0;
    mem_sel_en = 1'b0;
    for (int i = 0; i < IO_WIN; i++)  if (win_idx_o == IDX_W'(i)) io_sel_en  = io_en[i];
    for (int j = 0; j < MEM_WIN; j++) if (win_idx_o == IDX_W'(j)) mem_sel_en = mem_en[j];
  end

  AST_IDLE_NO_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !hit_o); // R9

  AST_SUB_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_kind_o == KIND_SUB) |-> fix_en[EN_SUB]); // R9

  AST_IO_WIN_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_kind_o == KIND_IO) |-> (io_sel_en && !req_mem_i)); // R5

  AST_MEM_WIN_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_kind_o == KIND_MEM) |-> (mem_sel_en && req_mem_i)); // R6

  AST_FIXED_IO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_kind_o == KIND_FIXED) |-> (!req_mem_i && win_idx_o < IDX_W'(3))); // R12

  AST_CLR_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (io_en == '0 && mem_en == '0 && fix_en[3:1] == 3'b0 &&
                      (!fix_en[EN_P80] || $past(clr_keep_p80_i)))); // R10

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i, 2) |-> !win_or); // R10
endmodule

bind decwin_top decwin_chk #(
  .IO_WIN(IO_WIN), .MEM_WIN(MEM_WIN), .IO_AW(IO_AW), .IO_SW(IO_SW),
  .MEM_AW(MEM_AW), .MEM_SW(MEM_SW), .IDX_W(IDX_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .clr_i          (clr_i),
  .clr_keep_p80_i (clr_keep_p80_i),
  .req_valid_i    (req_valid_i),
  .req_mem_i      (req_mem_i),
  .hit_o          (hit_o),
  .hit_kind_o     (hit_kind_o),
  .win_idx_o      (win_idx_o),
  .fix_en         (fix_en),
  .io_en          (io_en),
  .mem_en         (mem_en),
  .io_base        (io_base),
  .io_size        (io_size),
  .mem_base       (mem_base),
  .mem_size       (mem_size)
);

// File: tb/decwin_top_tb.sv
module decwin_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [5:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        clr_i = 1'b0;
  logic        clr_keep_p80_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_mem_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        hit_o;
  logic [2:0]  hit_kind_o;
  logic [2:0]  win_idx_o;

  always #4 clk_i = ~clk_i;

  decwin_top u_dut (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_dec, m_ext;
  logic [15:0] m_iob [8];
  logic [7:0]  m_ios [8];
  logic [31:0] m_mb  [4];
  logic [15:0] m_ms  [4];

  function automatic bit io_on(int i);
    return (i < 4) ? m_dec[4+i] : m_ext[i-4];
  endfunction
  function automatic bit mem_on(int j);
    return (j < 2) ? m_dec[8+j] : m_ext[4+j-2];
  endfunction

  // returns {hit, kind[2:0], idx[2:0]}
  function automatic logic [6:0] exp_dec(bit v, bit m, logic [31:0] a);
    logic [15:0] a16 = a[15:0];
    if (v && !m) begin
      if (m_dec[0] && a16 == 16'h80) return {1'b1, 3'd1, 3'd0};
      if (m_dec[1] && (a16 == 16'h60 || a16 == 16'h64)) return {1'b1, 3'd1, 3'd1};
      if (m_dec[2] && (a16 == 16'h2E || a16 == 16'h2F)) return {1'b1, 3'd1, 3'd2};
      for (int i = 0; i < 8; i++)
        if (io_on(i) && a16 >= m_iob[i] && 32'(a16) <= 32'(m_iob[i]) + 32'(m_ios[i]))
          return {1'b1, 3'd2, 3'(i)};
    end
    if (v && m) begin
      for (int j = 0; j < 4; j++)
        if (mem_on(j) && a >= m_mb[j] && 64'(a) <= 64'(m_mb[j]) + 64'(m_ms[j]))
          return {1'b1, 3'd3, 3'(j)};
    end
    if (v && m_dec[3]) return {1'b1, 3'd4, 3'd0};
    return 7'd0;
  endfunction

  function automatic logic [31:0] exp_rd(logic [5:0] a);
    if (a == 6'h00) return m_dec;
    if (a == 6'h01) return m_ext;
    if (a >= 6'h10 && a < 6'h18) return 32'(m_iob[a-6'h10]);
    if (a >= 6'h18 && a < 6'h20) return 32'(m_ios[a-6'h18]);
    if (a >= 6'h20 && a < 6'h24) return m_mb[a-6'h20];
    if (a >= 6'h28 && a < 6'h2C) return 32'(m_ms[a-6'h28]);
    return 32'd0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(posedge clk_i);
    if (a == 6'h00) m_dec = d & 32'h3FF;
    else if (a == 6'h01) m_ext = d & 32'h3F;
    else if (a >= 6'h10 && a < 6'h18) m_iob[a-6'h10] = d[15:0];
    else if (a >= 6'h18 && a < 6'h20) m_ios[a-6'h18] = d[7:0];
    else if (a >= 6'h20 && a < 6'h24) m_mb[a-6'h20] = d;
    else if (a >= 6'h28 && a < 6'h2C) m_ms[a-6'h28] = d[15:0];
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd(string tag, logic [5:0] a);
    @(negedge clk_i);
    cfg_addr_i = a;
    #1 check(tag, cfg_rdata_o, exp_rd(a));
  endtask

  task automatic dec(string tag, bit v, bit m, logic [31:0] a);
    logic [6:0] e;
    @(negedge clk_i);
    req_valid_i = v; req_mem_i = m; req_addr_i = a;
    e = exp_dec(v, m, a);
    #1 check(tag, {25'd0, hit_o, hit_kind_o, win_idx_o}, {25'd0, e});
  endtask

  task automatic do_clr(bit keep);
    @(negedge clk_i);
    clr_i = 1'b1; clr_keep_p80_i = keep;
    cfg_we_i = 1'b1; cfg_addr_i = 6'h10; cfg_wdata_i = 32'h1234; // must be ignored
    @(posedge clk_i);
    m_dec = keep ? (m_dec & 32'h1) : 32'h0;
    m_ext = 32'h0;
    @(negedge clk_i);
    clr_i = 1'b0; clr_keep_p80_i = 1'b0;
    cfg_addr_i = 6'h00;
    #1 check("R10 enables after first clear step", cfg_rdata_o, m_dec);
    cfg_addr_i = 6'h20; // write during second step also ignored
    cfg_wdata_i = 32'hDEAD_BEEF;
    @(posedge clk_i);
    for (int i = 0; i < 8; i++) begin m_iob[i] = '0; m_ios[i] = '0; end
    for (int j = 0; j < 4; j++) begin m_mb[j] = '0; m_ms[j] = '0; end
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [5:0] ra;
    logic [31:0] rdat, ab;
    void'($urandom(32'h0C0FFEE));
    m_dec = '0; m_ext = '0;
    for (int i = 0; i < 8; i++) begin m_iob[i] = '0; m_ios[i] = '0; end
    for (int j = 0; j < 4; j++) begin m_mb[j] = '0; m_ms[j] = '0; end
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;

    // R1
    rd("R1 reset primary enable", 6'h00);
    rd("R1 reset extended enable", 6'h01);
    rd("R1 reset io base 3", 6'h13);
    rd("R1 reset mmio size 1", 6'h29);
    dec("R1 no claim after reset", 1, 0, 32'h80);

    // R2
    wr(6'h00, 32'h1);
    dec("R2 port 0x80", 1, 0, 32'h80);
    dec("R2 port 0x81 not claimed", 1, 0, 32'h81);
    dec("R12 mem cycle at 0x80", 1, 1, 32'h80);
    dec("R12 io upper bits ignored", 1, 0, 32'hABCD_0080);
    // R3 R4
    wr(6'h00, 32'h6);
    dec("R2 0x80 off with bit clear", 1, 0, 32'h80);
    dec("R3 port 0x60", 1, 0, 32'h60);
    dec("R3 port 0x64", 1, 0, 32'h64);
    dec("R3 port 0x62", 1, 0, 32'h62);
    dec("R4 port 0x2E", 1, 0, 32'h2E);
    dec("R4 port 0x2F", 1, 0, 32'h2F);
    dec("R9 invalid never claimed", 0, 0, 32'h2E);

    // R5: one-byte window, disabled window
    wr(6'h10, 32'h0300);
    wr(6'h18, 32'h0);
    dec("R5 window disabled", 1, 0, 32'h300);
    wr(6'h00, 32'h10);
    dec("R5 one-byte window hit", 1, 0, 32'h300);
    dec("R5 one-byte window miss above", 1, 0, 32'h301);
    dec("R5 miss below", 1, 0, 32'h2FF);
    // R7: window 5 through extended register
    wr(6'h15, 32'hFFF0);
    wr(6'h1D, 32'hFF);
    dec("R7 ext window off", 1, 0, 32'hFFFF);
    wr(6'h01, 32'h2);
    dec("R7 ext window 5 hit top", 1, 0, 32'hFFFF);
    dec("R5 io upper bound no wrap", 1, 0, 32'h0000);
    // R6: mmio window 2 at top of space
    wr(6'h22, 32'hFFFF_FFF0);
    wr(6'h2A, 32'hFFFF);
    wr(6'h01, 32'h12);
    dec("R6 mmio hit at top", 1, 1, 32'hFFFF_FFFF);
    dec("R6 mmio no wrap to 0", 1, 1, 32'h0);
    dec("R12 io cycle vs mmio window", 1, 0, 32'hFFFF_FFF5);
    // R8: overlapping windows and fixed precedence
    wr(6'h11, 32'h0300); wr(6'h19, 32'h10);
    wr(6'h13, 32'h0300); wr(6'h1B, 32'h10);
    wr(6'h00, 32'hA1);
    dec("R8 lowest index 1 wins", 1, 0, 32'h305);
    wr(6'h13, 32'h0070); wr(6'h1B, 32'h20);
    dec("R8 fixed beats window 3", 1, 0, 32'h80);
    dec("R8 window 3 near fixed", 1, 0, 32'h81);
    // R9
    dec("R9 unmatched not claimed", 1, 1, 32'h1234_5678);
    wr(6'h00, 32'hA9);
    dec("R9 subtractive claim", 1, 1, 32'h1234_5678);
    dec("R9 subtractive io", 1, 0, 32'h0555);
    // R11
    wr(6'h18, 32'hFFFF_FFFF);
    rd("R11 io size masked", 6'h18);
    wr(6'h00, 32'hFFFF_FFFF);
    rd("R11 primary enable masked", 6'h00);
    wr(6'h3F, 32'hFFFF_FFFF);
    rd("R11 unmapped reads zero", 6'h3F);
    rd("R11 mmio base readback", 6'h22);

    // R10
    do_clr(1'b1);
    rd("R10 io base zeroed", 6'h15);
    rd("R10 mmio base zeroed", 6'h22);
    rd("R10 ext zeroed", 6'h01);
    dec("R10 p80 kept", 1, 0, 32'h80);
    wr(6'h00, 32'h3FF);
    do_clr(1'b0);
    rd("R10 p80 dropped", 6'h00);
    dec("R10 nothing claimed", 1, 0, 32'h80);

    // random phase
    for (int r = 0; r < 600; r++) begin
      for (int w = 0; w < 3; w++) begin
        case ($urandom_range(0, 5))
          0: ra = 6'h00;
          1: ra = 6'h01;
          2: ra = 6'h10 + 6'($urandom_range(0, 15));
          3: ra = 6'h20 + 6'($urandom_range(0, 3));
          4: ra = 6'h28 + 6'($urandom_range(0, 3));
          default: ra = 6'($urandom_range(0, 63));
        endcase
        rdat = $urandom();
        if (ra >= 6'h18 && ra < 6'h20) rdat = rdat & 32'h0F;
        if (ra >= 6'h28 && ra < 6'h2C) rdat = rdat & 32'h3F;
        if (ra >= 6'h10 && ra < 6'h18) rdat = rdat & 32'h00F0;
        if (ra >= 6'h20 && ra < 6'h24) rdat = rdat & 32'hF000_00F0;
        wr(ra, rdat);
      end
      if (r % 97 == 50) do_clr($urandom_range(0, 1) == 1);
      rd("R11 random readback", 6'($urandom_range(0, 47)));
      for (int k = 0; k < 6; k++) begin
        bit m = $urandom_range(0, 1) == 1;
        if (m) ab = m_mb[$urandom_range(0, 3)];
        else   ab = {16'($urandom()), m_iob[$urandom_range(0, 7)]};
        case ($urandom_range(0, 3))
          0: ab = ab + 32'($urandom_range(0, 80));
          1: ab = ab - 32'($urandom_range(0, 3));
          2: if (!m) ab[15:0] = 16'($urandom_range(0, 3) == 0 ? 16'h80 : 16'h2E + 16'($urandom_range(0, 1)));
          default: ab = ab + 32'($urandom_range(0, 16));
        endcase
        dec("R8 random decode", $urandom_range(0, 7) != 0, m, ab);
      end
    end

    done = 1;
    finish_run();
  end
endmodule